// File: doc/BRIEF.md
# Sparse Page-Allocating Memory

This block presents a wide logical address space through a simple request/ready bus port while keeping only a small pool of physical 4096-byte page frames. A page receives a frame the first time a nonzero value is written to it, provided the capacity budget allows. A fully associative tag table maps logical page numbers to frames. Pages without a frame read as zero. Writes to such pages that cannot allocate a frame are silently dropped.

An access carries an address, a write flag, a size code and write data. The bus issues a one-cycle `req_i` while the block is idle, then waits for the one-cycle `ready_o`. When `ready_o` is high, the read data and the misalignment flag are valid. When a frame is allocated, a sequencer first clears that frame to zero word by word and then applies the triggering write. The synchronous reset releases every mapping and returns the capacity accounting to empty.

Top module: `sparse_page_store`

## Requirements
- R1: The page number is the address shifted right by 12 bits and the in-page offset is the low 12 bits. Distinct pages, including the highest page 0xFFFFF, hold independent data. Addresses within one page share one frame.
- R2: A read from a page without a frame returns all zeros and changes no state.
- R3: A write allocates a frame only when all three conditions hold: the page has no frame, the write data masked to the access size is nonzero, and bytes-in-use plus 4096 is strictly less than MAX_BYTES.
- R4: A freshly allocated frame reads as zero in every byte that the triggering write did not cover.
- R5: A write to a page without a frame that fails the allocation condition has no effect. This covers a zero value and an exhausted pool.
- R6: A write to a page that already has a frame always updates its bytes, even when the value is zero.
- R7: Each allocation adds 4096 to bytes-in-use. With the defaults (4 frames, MAX_BYTES = 20480), exactly four pages can be mapped and a fifth nonzero write to a new page is dropped.
- R8: Reset removes every mapping and clears bytes-in-use and the frame free pointer. Afterwards all pages read as zero and four fresh pages can be allocated again.
- R9: The size code selects the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Data is little-endian: the byte at the lowest address is data bits 7:0. Read data is zero-extended above the access width.
- R10: An access whose address is not a multiple of its width returns `err_o` = 1 together with `ready_o`, with read data zero, and has no effect on any state.
- R11: Each request pulse taken while the block is idle produces exactly one `ready_o` pulse of one cycle. Requests that do not allocate complete within 3 cycles. After reset, `ready_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all mappings |
| req_i | input | 1 | One-cycle request strobe, taken while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| wdata_i | input | 64 | Write data, least significant bytes used |
| rdata_o | output | 64 | Read data, valid with ready_o |
| ready_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned access flag, valid with ready_o |

## Verification
Two functions meet in a single transaction: the allocation decision for an unmapped page and the merge of the triggering write into the frame that has just been cleared. The same transaction is also where the capacity limit applies. The bench provokes this by writing nonzero data of every width into fresh pages and then reading the surrounding bytes and words. These results must show the new bytes in little-endian place and zeros everywhere else. Separately, the bench drives the pool to exactly four frames and then sends one more nonzero write, which must leave that page reading zero. All expected values come from a byte-level model in the bench, built from the requirements.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_FILL  = 3'd2,
    ST_APPLY = 3'd3,
    ST_RD    = 3'd4
  } seq_state_e;

  // lane mask of an access starting at lane 0
  function automatic logic [7:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    width_mask = 8'h01;
      2'd1:    width_mask = 8'h03;
      2'd2:    width_mask = 8'h0F;
      default: width_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic is_misaligned(input logic [2:0] lo, input logic [1:0] sz);
    case (sz)
      2'd0:    is_misaligned = 1'b0;
      2'd1:    is_misaligned = lo[0];
      2'd2:    is_misaligned = |lo[1:0];
      default: is_misaligned = |lo;
    endcase
  endfunction

endpackage

// File: rtl/sps_lane_align.sv
module sps_lane_align
  import sps_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [2:0]  lane,
  input  logic [63:0] wdata,
  input  logic [63:0] rword,
  output logic [7:0]  be,
  output logic [63:0] wshift,
  output logic [63:0] rext,
  output logic        data_nz
);

  logic [7:0]  mask;
  logic [63:0] mask64;
  logic [63:0] rshift;
  logic [5:0]  shamt;

  assign mask   = width_mask(size);
  assign shamt  = {lane, 3'b000};
  assign be     = mask << lane;
  assign wshift = wdata << shamt;
  assign rshift = rword >> shamt;

  for (genvar b = 0; b < 8; b++) begin : g_byte
    assign mask64[8*b +: 8] = {8{mask[b]}};
  end

  assign rext    = rshift & mask64;
  assign data_nz = |(wdata & mask64);

endmodule

// File: rtl/sps_tag_cam.sv
module sps_tag_cam #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 20,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PAGE_W-1:0]     look_page,
  input  logic                  alloc_en,
  input  logic [IDX_W-1:0]      alloc_idx,
  input  logic [PAGE_W-1:0]     alloc_page,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx,
  output logic [NUM_FRAMES-1:0] match_vec
);

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_entry
    logic              valid_q;
    logic [PAGE_W-1:0] tag_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
      end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
        valid_q <= 1'b1;
        tag_q   <= alloc_page;
      end
    end

    assign match_vec[i] = valid_q && (tag_q == look_page);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/sps_frame_ram.sv
module sps_frame_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    be,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < 8; l++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[l]) mem[addr] <= wdata[8*l +: 8];
      rdata[8*l +: 8] <= mem[addr];
    end
  end

endmodule

// File: rtl/sparse_page_store.sv
module sparse_page_store
  import sps_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_FRAMES = 4,
  parameter int MAX_BYTES  = (NUM_FRAMES + 1) * PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              ready_o,
  output logic              err_o
);

  localparam int OFFSET_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W   = ADDR_W - OFFSET_W;
  localparam int WORDS    = PAGE_BYTES / 8;
  localparam int WORD_W   = OFFSET_W - 3;
  localparam int FRAME_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int RAM_AW   = FRAME_W + WORD_W;
  localparam int USED_W   = $clog2(MAX_BYTES) + 2;
  localparam int CNT_W    = FRAME_W + 1;

  seq_state_e          state_q;
  logic                we_q;
  logic [PAGE_W-1:0]   page_q;
  logic [OFFSET_W-1:0] off_q;
  logic [1:0]          size_q;
  logic [63:0]         wdata_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [WORD_W-1:0]   fill_q;
  logic [CNT_W-1:0]    free_q;
  logic [USED_W-1:0]   used_q;

  logic                  hit;
  logic [FRAME_W-1:0]    hit_idx;
  logic [NUM_FRAMES-1:0] match_vec;
  logic [7:0]            be;
  logic [63:0]           wshift, rext;
  logic                  wr_nz, misal, cap_ok, alloc_go;
  logic [RAM_AW-1:0]     ram_addr;
  logic                  ram_we;
  logic [7:0]            ram_be;
  logic [63:0]           ram_wd, ram_rd;
  logic [WORD_W-1:0]     word_idx;

  assign word_idx = off_q[OFFSET_W-1:3];
  assign misal    = is_misaligned(off_q[2:0], size_q);
  assign cap_ok   = ((used_q + USED_W'(PAGE_BYTES)) < USED_W'(MAX_BYTES))
                 && (free_q < CNT_W'(NUM_FRAMES));
  assign alloc_go = (state_q == ST_LOOK) && we_q && !misal && !hit && wr_nz && cap_ok;

  sps_tag_cam #(
    .NUM_FRAMES(NUM_FRAMES),
    .PAGE_W    (PAGE_W),
    .IDX_W     (FRAME_W)
  ) cam_i (
    .clk       (clk),
    .rst       (rst),
    .look_page (page_q),
    .alloc_en  (alloc_go),
    .alloc_idx (free_q[FRAME_W-1:0]),
    .alloc_page(page_q),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .match_vec (match_vec)
  );

  sps_lane_align align_i (
    .size   (size_q),
    .lane   (off_q[2:0]),
    .wdata  (wdata_q),
    .rword  (ram_rd),
    .be     (be),
    .wshift (wshift),
    .rext   (rext),
    .data_nz(wr_nz)
  );

  sps_frame_ram #(.AW(RAM_AW)) ram_i (
    .clk  (clk),
    .addr (ram_addr),
    .we   (ram_we),
    .be   (ram_be),
    .wdata(ram_wd),
    .rdata(ram_rd)
  );

  // memory port steering
  always_comb begin
    ram_addr = {hit_idx, word_idx};
    ram_we   = 1'b0;
    ram_be   = be;
    ram_wd   = wshift;
    case (state_q)
      ST_LOOK: ram_we = we_q && hit && !misal;
      ST_FILL: begin
        ram_addr = {frame_q, fill_q};
        ram_we   = 1'b1;
        ram_be   = 8'hFF;
        ram_wd   = '0;
      end
      ST_APPLY: begin
        ram_addr = {frame_q, word_idx};
        ram_we   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      page_q  <= '0;
      off_q   <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      frame_q <= '0;
      fill_q  <= '0;
      free_q  <= '0;
      used_q  <= '0;
      rdata_o <= '0;
      ready_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      err_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            we_q    <= we_i;
            page_q  <= addr_i[ADDR_W-1:OFFSET_W];
            off_q   <= addr_i[OFFSET_W-1:0];
            size_q  <= size_i;
            wdata_q <= wdata_i;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (misal) begin
            err_o   <= 1'b1;
            ready_o <= 1'b1;
            rdata_o <= '0;
            state_q <= ST_IDLE;
          end else if (!we_q) begin
            if (hit) begin
              state_q <= ST_RD;
            end else begin
              rdata_o <= '0;
              ready_o <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (alloc_go) begin
            frame_q <= free_q[FRAME_W-1:0];
            free_q  <= free_q + 1'b1;
            used_q  <= used_q + USED_W'(PAGE_BYTES);
            fill_q  <= '0;
            state_q <= ST_FILL;
          end else begin
            rdata_o <= '0;
            ready_o <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FILL: begin
          fill_q <= fill_q + 1'b1;
          if (fill_q == WORD_W'(WORDS - 1)) state_q <= ST_APPLY;
        end
        ST_APPLY: begin
          rdata_o <= '0;
          ready_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RD: begin
          rdata_o <= rext;
          ready_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sparse_page_store_chk.sv
module sparse_page_store_chk #(
  parameter int USED_W     = 16,
  parameter int MAX_BYTES  = 20480,
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_BYTES = 4096
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ready_o,
  input logic                  err_o,
  input logic [63:0]           rdata_o,
  input logic [USED_W-1:0]     used_q,
  input logic                  we_q,
  input logic                  wr_nz,
  input logic                  hit,
  input logic [NUM_FRAMES-1:0] match_vec
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  // R11: completion is a single-cycle pulse
  p_ready_single_r11: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R10: error flag only accompanies completion
  p_err_with_ready_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ready_o);

  // R10: a flagged access returns zero data
  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> rdata_o == 64'd0);

  // R1: no two tag entries claim the same page
  p_tag_unique_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R7: bytes-in-use stays under the budget and the pool
  p_used_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (used_q < USED_W'(MAX_BYTES)) && (used_q <= USED_W'(NUM_FRAMES * PAGE_BYTES)));

  // R3: growth of bytes-in-use follows a nonzero write that missed
  p_alloc_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && used_q != $past(used_q)) |->
      ($past(we_q) && $past(wr_nz) && !$past(hit)
       && used_q == $past(used_q) + USED_W'(PAGE_BYTES)));

endmodule

bind sparse_page_store sparse_page_store_chk #(
  .USED_W    (USED_W),
  .MAX_BYTES (MAX_BYTES),
  .NUM_FRAMES(NUM_FRAMES),
  .PAGE_BYTES(PAGE_BYTES)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ready_o  (ready_o),
  .err_o    (err_o),
  .rdata_o  (rdata_o),
  .used_q   (used_q),
  .we_q     (we_q),
  .wr_nz    (wr_nz),
  .hit      (hit),
  .match_vec(match_vec)
);

// File: tb/sparse_page_store_tb.sv
module sparse_page_store_tb_top;

  localparam int MAXB = 20480;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        ready_o, err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sparse_page_store dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ready_o(ready_o), .err_o(err_o)
  );

  // byte-level model
  logic [7:0]  bmem [logic [31:0]];
  logic [19:0] pg_list [4];
  int          npg;
  int unsigned used;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [31:0] a);
    for (int i = 0; i < npg; i++) if (pg_list[i] == a[31:12]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    bmem.delete();
    npg  = 0;
    used = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] wd, input string rq);
    int nb;
    bit mis, allocd;
    logic [63:0] mask, exp_rd, got_rd;
    bit got_err;
    int cyc;
    nb     = 1 << sz;
    mis    = (a % nb) != 0;
    mask   = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
    exp_rd = '0;
    allocd = 1'b0;
    if (!mis) begin
      if (we) begin
        if (!is_mapped(a) && ((wd & mask) != 0) && (used + 4096 < MAXB)) begin
          pg_list[npg] = a[31:12];
          npg++;
          used += 4096;
          allocd = 1'b1;
        end
        if (is_mapped(a))
          for (int i = 0; i < nb; i++) bmem[a + i] = wd[8*i +: 8];
      end else if (is_mapped(a)) begin
        for (int i = 0; i < nb; i++)
          if (bmem.exists(a + i)) exp_rd[8*i +: 8] = bmem[a + i];
      end
    end
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0;
    cyc = 1;
    while (!ready_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    got_rd  = rdata_o;
    got_err = err_o;
    chk(got_err == mis, mis ? "R10" : rq, 64'(got_err), 64'(mis));
    chk(got_rd == exp_rd, rq, got_rd, exp_rd);
    if (!allocd) chk(cyc <= 3, "R11", 64'(cyc), 64'd3);
    @(negedge clk);
    chk(!ready_o, "R11", 64'(ready_o), 64'd0);
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a, input int k);
    return {a ^ 32'hA5C3_0F1E, ~a} + 64'(k) * 64'h0101_0203_0507_0B0D;
  endfunction

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ready_o && !err_o, "R11", {62'd0, ready_o, err_o}, 64'd0);

    // R2: unmapped reads
    access(0, 32'h0000_0000, 2'd3, '0, "R2");
    access(0, 32'h1234_5678, 2'd0, '0, "R2");
    access(0, 32'hFFFF_FFF8, 2'd3, '0, "R2");

    // R10: misalignment sweep with nonzero data
    for (int sz = 1; sz < 4; sz++)
      for (int lo = 1; lo < 8; lo++)
        if (lo % (1 << sz) != 0) begin
          access(1, 32'h0000_7000 + lo, 2'(sz), 64'hFFFF_FFFF_FFFF_FFFF, "R10");
          access(0, 32'h0000_7000 + lo, 2'(sz), '0, "R10");
        end
    access(0, 32'h0000_7000, 2'd3, '0, "R10");

    // R5: zero write to an unmapped page is dropped
    access(1, 32'h0000_1008, 2'd3, 64'd0, "R5");
    access(0, 32'h0000_1008, 2'd3, '0, "R5");
    // R3 zero in lanes beyond width does not count
    access(1, 32'h0000_1010, 2'd0, 64'hFFFF_FFFF_FFFF_FF00, "R3");
    access(0, 32'h0000_1010, 2'd3, '0, "R3");

    // R4: allocation by a single byte, neighbours read zero
    access(1, 32'h0000_1123, 2'd0, 64'h5A, "R3");
    access(0, 32'h0000_1120, 2'd3, '0, "R4");
    access(0, 32'h0000_1000, 2'd3, '0, "R4");
    access(0, 32'h0000_1FF8, 2'd3, '0, "R4");

    // R9: width/offset sweep
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 32; off += (1 << sz))
        access(1, 32'h0000_2000 + 32'(64 * sz) + off, 2'(sz), pat(32'(off), sz), "R9");
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 256; off += (1 << sz))
        access(0, 32'h0000_2000 + off, 2'(sz), '0, "R9");

    // R6: zero writes to a mapped page take effect
    access(1, 32'h0000_2000, 2'd3, 64'd0, "R6");
    access(1, 32'h0000_2042, 2'd1, 64'd0, "R6");
    access(0, 32'h0000_2000, 2'd3, '0, "R6");
    access(0, 32'h0000_2040, 2'd3, '0, "R6");

    // R1: top page and same offsets in distinct pages
    access(1, 32'hFFFF_F010, 2'd3, 64'h0123_4567_89AB_CDEF, "R1");
    access(0, 32'h0000_0010, 2'd3, '0, "R1");
    access(0, 32'h0000_1010, 2'd3, '0, "R1");
    access(0, 32'hFFFF_F014, 2'd2, '0, "R1");
    access(0, 32'hFFFF_F010, 2'd3, '0, "R1");

    // R7: fourth frame fits, fifth is dropped
    access(1, 32'h0000_3010, 2'd2, 64'hDEAD_BEEF, "R7");
    access(0, 32'h0000_3010, 2'd2, '0, "R7");
    access(1, 32'h0000_6000, 2'd3, 64'h1111_2222_3333_4444, "R5");
    access(0, 32'h0000_6000, 2'd3, '0, "R5");
    access(1, 32'h0000_3018, 2'd3, 64'h77, "R6");
    access(0, 32'h0000_3018, 2'd3, '0, "R6");

    // R8: reset releases everything, pool usable again
    do_reset();
    chk(!ready_o && !err_o, "R8", {62'd0, ready_o, err_o}, 64'd0);
    access(0, 32'h0000_1120, 2'd3, '0, "R8");
    access(0, 32'h0000_2008, 2'd3, '0, "R8");
    access(0, 32'hFFFF_F010, 2'd3, '0, "R8");
    for (int p = 6; p < 11; p++) begin
      access(1, (32'(p) << 12) + 32'h18, 2'd3, pat(32'(p), 1), "R8");
      access(0, (32'(p) << 12) + 32'h18, 2'd3, '0, "R7");
      access(0, (32'(p) << 12) + 32'h20, 2'd3, '0, "R4");
    end

    done = 1'b1;
  end

  initial begin
    int cnt;
    cnt = 0;
    while (!done && cnt < 150000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=done", cnt);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule